// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block owns the 64-bit control register that places the memory-mapped PCIe configuration window in the address map. Software writes the register through a small write port with per-byte enables and reads it back as a whole. Every write that touches at least one byte decodes the register into a live mapping: an enable, a window size of 64, 128 or 256 MiB, and a base address aligned to that size.

A separate lookup port takes a memory address and reports, one clock later, whether it falls inside the live window and, if so, its byte offset from the window base. The offset feeds the logic that turns it into bus, device, function and register numbers. If a write selects the reserved size code, the register keeps the written value but the live mapping stays as it was, and a one-cycle error pulse is raised.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads back 64'h0000_0000_B000_0000 (window off, 256 MiB code, base 0xB000_0000), no lookup hits and the error output is low.
- R2: On a cycle with the write strobe high, byte lane b of the register takes byte b of the write data only if byte enable b is set; the new value is visible on the read port from the next cycle.
- R3: Register encoding: bit 0 turns the window on; bits [2:1] pick the size, 00 for 256 MiB, 01 for 128 MiB, 10 for 64 MiB and 11 reserved; the base is taken from bits [38:28], [38:27] or [38:26] for those sizes, and all other bits have no effect on the mapping.
- R4: A lookup presented with its valid high reports a hit on the next cycle when the window is on and base <= address < base + size.
- R5: On a hit the offset output is the address minus the base; without a hit it is zero.
- R6: A write that leaves the reserved size code in the register keeps the previous mapping (enable, base and size), raises the error output for exactly the next cycle, and the register still reads back the written value.
- R7: Any write with at least one byte enable set recomputes the mapping from the whole merged register, even if the enable and size bytes were not written; a write with no byte enable set changes neither register nor mapping.
- R8: A lookup in the same cycle as a mapping-changing write is judged against the mapping before that write; the new mapping applies to lookups from the following cycle.
- R9: With the window off no address hits, regardless of base and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_be | input | 8 | Byte enables of the write |
| cfg_wr_data | input | 64 | Write data |
| cfg_rd_data | output | 64 | Current register contents |
| cfg_len_err | output | 1 | One-cycle pulse after a write leaving the reserved size code |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 39 | Address to look up |
| lk_hit | output | 1 | Registered hit result |
| lk_offset | output | 28 | Registered offset inside the window |

## Verification
The two functions that can share a cycle are a register write that moves, resizes or switches the window and an address lookup. The bench issues a write and a lookup together at an address that lies inside only one of the old and new windows, then repeats the lookup alone in the next cycle. The same-cycle result must follow the old mapping and the repeated one the new, with both computed by the bench from its own model of the register.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_128M = 2'b01,
    SZ_64M  = 2'b10,
    SZ_RSVD = 2'b11
  } win_size_e;

  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned SZ_LSB     = 1;
  localparam int unsigned MIN_LG     = 26;
  localparam int unsigned MAX_LG     = 28;
  localparam int unsigned LG_W       = 5;

  // log2 of the window size for a size code; reserved maps to the largest
  function automatic logic [LG_W-1:0] size_lg(input logic [1:0] code);
    logic [LG_W-1:0] lg;
    case (win_size_e'(code))
      SZ_128M: lg = LG_W'(MAX_LG - 1);
      SZ_64M:  lg = LG_W'(MIN_LG);
      default: lg = LG_W'(MAX_LG);
    endcase
    return lg;
  endfunction

endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
  parameter int unsigned       REG_W   = 64,
  parameter int unsigned       ADDR_W  = 39,
  parameter logic [REG_W-1:0]  RST_VAL = 64'h0000_0000_B000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_W/8-1:0]      wr_be,
  input  logic [REG_W-1:0]        wr_data,
  output logic [REG_W-1:0]        reg_q,
  output logic [ADDR_W-1:0]       dec_bits,
  output logic                    upd
);
  localparam int unsigned NBYTES = REG_W / 8;

  logic [REG_W-1:0] reg_nxt;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      always_comb begin
        if (wr_en && wr_be[b]) reg_nxt[8*b +: 8] = wr_data[8*b +: 8];
        else                   reg_nxt[8*b +: 8] = reg_q[8*b +: 8];
      end
    end
  endgenerate

  always_comb begin
    upd      = wr_en && (|wr_be);
    dec_bits = reg_nxt[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   reg_q <= RST_VAL;
    else if (upd) reg_q <= reg_nxt;
  end

  // R7: no enabled lane means the register keeps its value
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (|wr_be)) |=> reg_q == $past(reg_q));

  // R2: an enabled lane takes the written byte
  p_lane0_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[0]) |=> reg_q[7:0] == $past(wr_data[7:0]));

  // R2: a disabled lane keeps its byte
  p_lane_top_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[NBYTES-1]) |=> reg_q[REG_W-1 -: 8] == $past(reg_q[REG_W-1 -: 8]));

endmodule

// File: rtl/cfgwin_map.sv
module cfgwin_map
  import cfgwin_pkg::*;
#(
  parameter int unsigned          ADDR_W  = 39,
  parameter logic [ADDR_W-1:0]    RST_LOW = 39'h00_B000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic [ADDR_W-1:0]    dec_bits,
  output logic                 map_en,
  output logic [ADDR_W-1:0]    map_base,
  output logic [LG_W-1:0]      map_lg,
  output logic                 len_err
);
  localparam logic [1:0]        RST_CODE = RST_LOW[SZ_LSB +: 2];
  localparam logic [LG_W-1:0]   RST_LG   = size_lg(RST_CODE);
  localparam logic [ADDR_W-1:0] RST_BASE = (RST_LOW >> RST_LG) << RST_LG;
  localparam logic              RST_EN   = RST_LOW[EN_BIT] && (RST_CODE != SZ_RSVD);

  logic [1:0]        code;
  logic              is_rsvd;
  logic [LG_W-1:0]   lg_d;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] base_d;
  logic              load;
  logic              err_d;

  always_comb begin
    code    = dec_bits[SZ_LSB +: 2];
    is_rsvd = (code == SZ_RSVD);
    lg_d    = size_lg(code);
    for (int i = 0; i < int'(ADDR_W); i++) begin
      keep_mask[i] = (i >= int'(lg_d));
    end
    base_d = dec_bits & keep_mask;
    load   = upd && !is_rsvd;
    err_d  = upd && is_rsvd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_en   <= RST_EN;
      map_base <= RST_BASE;
      map_lg   <= RST_LG;
    end else if (load) begin
      map_en   <= dec_bits[EN_BIT];
      map_base <= base_d;
      map_lg   <= lg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_err <= 1'b0;
    else        len_err <= err_d;
  end

  // R6: reserved size code keeps the mapping
  p_rsvd_keeps_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_rsvd) |=> (map_en == $past(map_en)) && (map_base == $past(map_base))
                         && (map_lg == $past(map_lg)));

  // R6: error pulse only follows a write
  p_err_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(upd));

  // R3: live size is always one of the three legal sizes
  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (map_lg >= LG_W'(MIN_LG)) && (map_lg <= LG_W'(MAX_LG)));

  // R7: without an update the mapping does not move
  p_map_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> map_base == $past(map_base));

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 39,
  parameter int unsigned OFF_W  = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  input  logic                 map_en,
  input  logic [ADDR_W-1:0]    map_base,
  input  logic [LG_W-1:0]      map_lg,
  output logic                 hit_q,
  output logic [OFF_W-1:0]     off_q
);
  logic [ADDR_W:0]   win_len;
  logic [ADDR_W:0]   win_end;
  logic [ADDR_W:0]   addr_x;
  logic              in_rng;
  logic              hit_d;
  logic [OFF_W-1:0]  off_d;

  always_comb begin
    win_len = {{ADDR_W{1'b0}}, 1'b1} << map_lg;
    win_end = {1'b0, map_base} + win_len;
    addr_x  = {1'b0, lk_addr};
    in_rng  = (addr_x >= {1'b0, map_base}) && (addr_x < win_end);
    hit_d   = lk_valid && map_en && in_rng;
    off_d   = hit_d ? (lk_addr[OFF_W-1:0] - map_base[OFF_W-1:0]) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      off_q <= '0;
    end else begin
      hit_q <= hit_d;
      off_q <= off_d;
    end
  end

  // R9: a hit needs the window switched on
  p_hit_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(map_en));

  // R4: a hit needs a valid lookup
  p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(lk_valid));

  // R5: offset is zero without a hit
  p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_q |-> off_q == '0);

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int unsigned      REG_W   = 64,
  parameter int unsigned      ADDR_W  = 39,
  parameter logic [63:0]      RST_VAL = 64'h0000_0000_B000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [REG_W/8-1:0]   cfg_wr_be,
  input  logic [REG_W-1:0]     cfg_wr_data,
  output logic [REG_W-1:0]     cfg_rd_data,
  output logic                 cfg_len_err,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_hit,
  output logic [MAX_LG-1:0]    lk_offset
);
  localparam int unsigned OFF_W = MAX_LG;

  logic [ADDR_W-1:0] dec_bits;
  logic              upd;
  logic              map_en;
  logic [ADDR_W-1:0] map_base;
  logic [LG_W-1:0]   map_lg;

  cfgwin_reg #(
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W),
    .RST_VAL (RST_VAL[REG_W-1:0])
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_be    (cfg_wr_be),
    .wr_data  (cfg_wr_data),
    .reg_q    (cfg_rd_data),
    .dec_bits (dec_bits),
    .upd      (upd)
  );

  cfgwin_map #(
    .ADDR_W  (ADDR_W),
    .RST_LOW (RST_VAL[ADDR_W-1:0])
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .dec_bits (dec_bits),
    .map_en   (map_en),
    .map_base (map_base),
    .map_lg   (map_lg),
    .len_err  (cfg_len_err)
  );

  cfgwin_match #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .map_en   (map_en),
    .map_base (map_base),
    .map_lg   (map_lg),
    .hit_q    (lk_hit),
    .off_q    (lk_offset)
  );

  // R8: the lookup result reflects the mapping held in the lookup cycle
  p_same_cycle_old_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !map_en) |=> !lk_hit);

endmodule

// File: tb/cfgwin_decoder_tb_top.sv
`timescale 1ns/1ps
module cfgwin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_be;
  logic [63:0] cfg_wr_data;
  logic [63:0] cfg_rd_data;
  logic        cfg_len_err;
  logic        lk_valid;
  logic [38:0] lk_addr;
  logic        lk_hit;
  logic [27:0] lk_offset;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [63:0] m_reg;
  logic        m_en;
  logic [63:0] m_base;
  int          m_lg;

  always #2 clk = ~clk;

  cfgwin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .cfg_len_err(cfg_len_err),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_offset(lk_offset)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional lookup in the same cycle
  task automatic cyc(input logic wen, input logic [7:0] be, input logic [63:0] d,
                     input logic lv, input logic [63:0] a, input string req);
    logic [63:0] aa;
    logic        e_hit;
    logic [63:0] e_off;
    logic        e_err;
    int          lg;
    aa = a & ((64'd1 << 39) - 64'd1);
    e_hit = lv && m_en && (aa >= m_base) && (aa < m_base + (64'd1 << m_lg));
    e_off = e_hit ? ((aa - m_base) & 64'h0FFF_FFFF) : 64'd0;
    @(negedge clk);
    cfg_wr_en = wen; cfg_wr_be = be; cfg_wr_data = d;
    lk_valid = lv; lk_addr = aa[38:0];
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_be = '0; lk_valid = 1'b0;
    e_err = 1'b0;
    if (wen && (be != 0)) begin
      for (int b = 0; b < 8; b++) if (be[b]) m_reg[8*b +: 8] = d[8*b +: 8];
      if (m_reg[2:1] == 2'b11) e_err = 1'b1;
      else begin
        lg = (m_reg[2:1] == 2'b00) ? 28 : (m_reg[2:1] == 2'b01) ? 27 : 26;
        m_en = m_reg[0];
        m_lg = lg;
        m_base = ((m_reg & ((64'd1 << 39) - 64'd1)) >> lg) << lg;
      end
    end
    chk({req, " hit"}, {63'd0, lk_hit}, {63'd0, e_hit});
    chk({req, " offset"}, {36'd0, lk_offset}, e_off);
    chk({req, " readback"}, cfg_rd_data, m_reg);
    chk({req, " err"}, {63'd0, cfg_len_err}, {63'd0, e_err});
  endtask

  task automatic look(input logic [63:0] a, input string req);
    cyc(1'b0, 8'h00, 64'd0, 1'b1, a, req);
  endtask

  task automatic probe_window(input string req);
    logic [63:0] ln;
    ln = 64'd1 << m_lg;
    look(m_base - 64'd1, req);
    look(m_base, req);
    look(m_base + 64'd1, req);
    look(m_base + (ln >> 1) + 64'h123, req);
    look(m_base + ln - 64'd1, req);
    look(m_base + ln, req);
    look(m_base + (64'd1 << 26), req);
    look(m_base + (64'd1 << 27), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] bases [4];
    bases[0] = 64'h0000_0000_B000_0000;
    bases[1] = 64'h0000_0040_0C00_0000;
    bases[2] = 64'h0000_007F_FC00_0000;
    bases[3] = 64'hFFFF_FF81_27FF_FFF0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_be = '0; cfg_wr_data = '0;
    lk_valid = 1'b0; lk_addr = '0;
    m_reg = 64'h0000_0000_B000_0000; m_en = 1'b0; m_base = 64'hB000_0000; m_lg = 28;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset readback", cfg_rd_data, 64'h0000_0000_B000_0000);
    chk("R1 reset err", {63'd0, cfg_len_err}, 64'd0);
    chk("R1 reset hit", {63'd0, lk_hit}, 64'd0);
    rst_n = 1'b1;
    look(64'hB000_0000, "R1 no hit after reset");
    look(64'hB800_0000, "R1 no hit after reset");

    // R3 R4 R5 R6 R9: sweep size code, enable and base
    for (int c = 0; c < 4; c++) begin
      for (int en = 0; en < 2; en++) begin
        for (int k = 0; k < 4; k++) begin
          logic [63:0] d;
          d = (bases[k] & ~64'h7) | (64'(c) << 1) | 64'(en);
          cyc(1'b1, 8'hFF, d, 1'b0, 64'd0, (c == 3) ? "R6 reserved write" : "R3 write");
          probe_window(en ? "R4 R5 window probe" : "R9 window probe");
        end
      end
    end

    // R2: single-lane writes
    for (int b = 0; b < 8; b++) begin
      cyc(1'b1, 8'(1 << b), ~m_reg ^ 64'h0102_0408_1020_4080, 1'b0, 64'd0, "R2 lane write");
      probe_window("R2 lane mapping");
    end

    // R7: base-only byte write recomputes mapping; empty enables change nothing
    cyc(1'b1, 8'hFF, 64'h0000_0000_C000_0001, 1'b0, 64'd0, "R7 setup");
    cyc(1'b1, 8'h08, 64'h0000_0000_E000_0000, 1'b0, 64'd0, "R7 base byte write");
    probe_window("R7 recomputed");
    cyc(1'b1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd0, "R7 empty enables");
    look(64'hE000_0000, "R7 unchanged mapping");
    look(64'hC000_0000, "R7 unchanged mapping");

    // R6: reserved write after a valid mapping keeps it
    cyc(1'b1, 8'h01, 64'h07, 1'b0, 64'd0, "R6 reserved code");
    look(64'hE000_0010, "R6 old mapping kept");
    look(64'hEFFF_FFFF, "R6 old mapping kept");

    // R8: write and lookup in the same cycle
    cyc(1'b1, 8'hFF, 64'h0000_0000_2000_0005, 1'b1, 64'h2000_0040, "R8 same cycle");
    look(64'h2000_0040, "R8 next cycle");
    cyc(1'b1, 8'hFF, 64'h0000_0000_4000_0001, 1'b1, 64'h2000_0040, "R8 same cycle move");
    look(64'h2000_0040, "R8 next cycle move");
    look(64'h4000_0040, "R8 next cycle move");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule